// File: doc/BRIEF.md
# Shared AHB Master for Two DMA Channels

This block puts a transmit DMA requester and a receive DMA requester onto one AHB master port. When the port is free, it picks one requesting channel and captures that channel's access description. The description gives the start address, the transfer size, the beat count, the direction and whether the address increments. The block then drives the access onto the bus as a pipelined run of address and data phases. Each channel gets a pulse for every beat that completes, a pulse when its access ends, and an error pulse when a slave rejects the access.

Arbitration is sticky. The channel that ran the last access keeps the port whenever it asks again. Each requester must drop its request once its access has been taken, so a waiting channel is served as soon as the current owner stops asking. Slaves may insert wait states. Slaves may also answer with the two-cycle ERROR, RETRY and SPLIT responses. RETRY and SPLIT make the master resume from the rejected beat. ERROR ends the access.

A channel raises `ch_req` with stable access fields and drops it after it sees `ch_start`. While the channel's beats are in their data phases, it keeps `ch_wdata` at the data of its oldest beat that has not yet completed, and moves to the next data on each `ch_beat_ok`.

Top module: `ahbm_dual_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `htrans` is IDLE (0) and all `ch_start`, `ch_beat_ok`, `ch_done` and `ch_err` bits are low.
- R2: When the port is idle and at least one request is high at a clock edge, the block grants one channel. If the previous owner is requesting, it gets the grant; otherwise the other channel does. Channel 0 counts as the owner after reset. `ch_start` for the granted channel pulses in the next cycle, together with the first address phase.
- R3: `hsize` carries the `ch_size` code: 0 for byte, 1 for halfword, 2 for word. In incrementing mode each beat's address is 1, 2 or 4 above the address of the previous beat.
- R4: Byte and halfword beats are all driven with `htrans` NONSEQ (2), and `hburst` is SINGLE (0).
- R5: For an incrementing word access of more than one beat, `hburst` is INCR (1), the first beat is NONSEQ (2) and every later beat is SEQ (3).
- R6: With `ch_fixed` high, every beat uses the start address and NONSEQ (2), and `hburst` is SINGLE (0).
- R7: While `hready` is low with an OKAY (0) response, the pending address phase (`haddr`, `htrans`) is held unchanged.
- R8: In the first cycle of a RETRY (2) or SPLIT (3) response, the block drives IDLE in the next cycle. After the second response cycle, it reissues the rejected beat as NONSEQ at that beat's address and then continues with the remaining beats.
- R9: In the first cycle of an ERROR (1) response, the block drives IDLE in the next cycle. After the second cycle, `ch_err` and `ch_done` of the owner pulse together and no further beat of that access is issued.
- R10: One cycle after each data phase that ends with OKAY, the owner's `ch_beat_ok` pulses and `ch_rdata` holds the `hrdata` of that beat. The owner's `ch_done` pulses together with the `ch_beat_ok` of the final beat.
- R11: `hwrite` follows the owner's `ch_write`. During a write data phase, `hwdata` equals the owner's `ch_wdata`.
- R12: `htrans` is IDLE (0) whenever no access is active, and BUSY (1) is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NCH | Access request per channel (0 = transmit, 1 = receive) |
| ch_addr | input | NCH x AW | Start address per channel |
| ch_size | input | NCH x 2 | Size code per channel: 0 byte, 1 halfword, 2 word |
| ch_beats | input | NCH x BW | Number of beats, at least 1 |
| ch_fixed | input | NCH | 1 keeps the address constant for every beat |
| ch_write | input | NCH | 1 for a write access, 0 for a read |
| ch_wdata | input | NCH x DW | Write data of the oldest beat not yet completed |
| ch_start | output | NCH | Access taken |
| ch_beat_ok | output | NCH | A beat completed with OKAY |
| ch_done | output | NCH | Access finished |
| ch_err | output | NCH | Access ended by an ERROR response |
| ch_rdata | output | DW | Data of the last completed beat |
| haddr | output | AW | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | DW | AHB write data |
| hrdata | input | DW | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 2 | AHB response |

## Verification
A granted request produces `ch_start` and its first address phase one cycle after the edge where it was sampled. Each OKAY data phase is reported by `ch_beat_ok` and `ch_rdata` one cycle after the edge that ends it. The first cycle of a non-OKAY response turns the bus to IDLE at the next edge, and the reissue, or the `ch_err`/`ch_done` pair, follows one cycle after the second response cycle. The bench model advances once per clock edge on the same inputs the design saw. It compares all outputs half a period later and checks `hwdata` just after the bench updates `ch_wdata`, so every result is sampled in the cycle it is due.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic [1:0] RSP_OKAY  = 2'd0;
  localparam logic [1:0] RSP_ERROR = 2'd1;
  localparam logic [1:0] RSP_RETRY = 2'd2;
  localparam logic [1:0] RSP_SPLIT = 2'd3;

  localparam logic [2:0] BURST_SINGLE = 3'd0;
  localparam logic [2:0] BURST_INCR   = 3'd1;

  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/ahbm_arb.sv
module ahbm_arb #(
  parameter int NCH = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           idle,
  output logic           take,
  output logic [IW-1:0]  grant_idx,
  output logic [IW-1:0]  owner_idx
);
  logic [IW-1:0] owner_q;
  logic          found;

  // Previous owner first, then the others in cyclic order behind it.
  always_comb begin
    grant_idx = owner_q;
    found     = req[owner_q];
    for (int k = 1; k < NCH; k++) begin
      if (!found && req[(int'(owner_q) + k) % NCH]) begin
        grant_idx = IW'((int'(owner_q) + k) % NCH);
        found     = 1'b1;
      end
    end
  end

  assign take      = idle && (|req);
  assign owner_idx = owner_q;

  always_ff @(posedge clk) begin
    if (rst) owner_q <= '0;
    else if (take) owner_q <= grant_idx;
  end
endmodule

// File: rtl/ahbm_req_sel.sv
module ahbm_req_sel
  import ahbm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int BW  = 5,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0][AW-1:0] ch_addr,
  input  logic [NCH-1:0][1:0]    ch_size,
  input  logic [NCH-1:0][BW-1:0] ch_beats,
  input  logic [NCH-1:0]         ch_fixed,
  input  logic [NCH-1:0]         ch_write,
  input  logic [IW-1:0]          sel,
  output logic [AW-1:0]          s_addr,
  output logic [1:0]             s_size,
  output logic [BW-1:0]          s_beats,
  output logic                   s_fixed,
  output logic                   s_write,
  output logic [2:0]             s_burst
);
  always_comb begin
    s_addr  = ch_addr[sel];
    s_size  = ch_size[sel];
    s_beats = ch_beats[sel];
    s_fixed = ch_fixed[sel];
    s_write = ch_write[sel];
    // Only incrementing word runs are announced as a burst.
    if (!s_fixed && s_size == SZ_WORD && s_beats > BW'(1)) s_burst = BURST_INCR;
    else s_burst = BURST_SINGLE;
  end
endmodule

// File: rtl/ahbm_xfer_eng.sv
module ahbm_xfer_eng
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [BW-1:0] st_beats,
  input  logic          st_fixed,
  input  logic          st_write,
  input  logic [2:0]    st_burst,
  output logic          busy,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  input  logic          hready,
  input  logic [1:0]    hresp,
  input  logic [DW-1:0] hrdata,
  output logic          dp_write,
  output logic          beat_ok,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  logic          busy_q, fixed_q, dp_q;
  logic [AW-1:0] addr_q, dp_addr_q;
  trans_e        trans_q;
  logic          write_q;
  logic [1:0]    size_q;
  logic [2:0]    burst_q;
  logic [BW-1:0] left_q;

  logic          acc, fin, kill, seq_ok;
  logic [AW-1:0] step;

  always_comb begin
    acc    = hready && (trans_q != TR_IDLE);
    fin    = dp_q && hready;
    kill   = dp_q && !hready && (hresp != RSP_OKAY);
    seq_ok = !fixed_q && (size_q == SZ_WORD);
    step   = fixed_q ? '0 : (AW'(1) << size_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      fixed_q   <= 1'b0;
      dp_q      <= 1'b0;
      addr_q    <= '0;
      dp_addr_q <= '0;
      trans_q   <= TR_IDLE;
      write_q   <= 1'b0;
      size_q    <= '0;
      burst_q   <= BURST_SINGLE;
      left_q    <= '0;
      beat_ok   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      beat_ok <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          addr_q  <= st_addr;
          trans_q <= TR_NONSEQ;
          write_q <= st_write;
          size_q  <= st_size;
          burst_q <= st_burst;
          fixed_q <= st_fixed;
          left_q  <= st_beats;
          dp_q    <= 1'b0;
        end
      end else begin
        if (fin) dp_q <= 1'b0;
        if (acc) begin
          dp_q      <= 1'b1;
          dp_addr_q <= addr_q;
          left_q    <= left_q - BW'(1);
          if (left_q > BW'(1)) begin
            addr_q  <= addr_q + step;
            trans_q <= seq_ok ? TR_SEQ : TR_NONSEQ;
          end else begin
            trans_q <= TR_IDLE;
          end
        end
        // First cycle of a two-cycle response: withdraw the next address.
        if (kill) trans_q <= TR_IDLE;
        if (fin) begin
          unique case (hresp)
            RSP_OKAY: begin
              beat_ok <= 1'b1;
              rdata   <= hrdata;
              if (left_q == '0) begin
                done   <= 1'b1;
                busy_q <= 1'b0;
              end
            end
            RSP_ERROR: begin
              err     <= 1'b1;
              done    <= 1'b1;
              busy_q  <= 1'b0;
              trans_q <= TR_IDLE;
              left_q  <= '0;
            end
            default: begin
              addr_q  <= dp_addr_q;
              trans_q <= TR_NONSEQ;
              left_q  <= left_q + BW'(1);
            end
          endcase
        end
      end
    end
  end

  assign busy     = busy_q;
  assign haddr    = addr_q;
  assign htrans   = trans_q;
  assign hwrite   = write_q;
  assign hsize    = {1'b0, size_q};
  assign hburst   = burst_q;
  assign dp_write = dp_q && write_q;
endmodule

// File: rtl/ahbm_dual_master.sv
module ahbm_dual_master
  import ahbm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BW  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         ch_req,
  input  logic [NCH-1:0][AW-1:0] ch_addr,
  input  logic [NCH-1:0][1:0]    ch_size,
  input  logic [NCH-1:0][BW-1:0] ch_beats,
  input  logic [NCH-1:0]         ch_fixed,
  input  logic [NCH-1:0]         ch_write,
  input  logic [NCH-1:0][DW-1:0] ch_wdata,
  output logic [NCH-1:0]         ch_start,
  output logic [NCH-1:0]         ch_beat_ok,
  output logic [NCH-1:0]         ch_done,
  output logic [NCH-1:0]         ch_err,
  output logic [DW-1:0]          ch_rdata,
  output logic [AW-1:0]          haddr,
  output logic [1:0]             htrans,
  output logic                   hwrite,
  output logic [2:0]             hsize,
  output logic [2:0]             hburst,
  output logic [DW-1:0]          hwdata,
  input  logic [DW-1:0]          hrdata,
  input  logic                   hready,
  input  logic [1:0]             hresp
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          take, busy, dp_write, e_ok, e_done, e_err;
  logic [IW-1:0] grant_idx, owner_idx;
  logic [AW-1:0] s_addr;
  logic [1:0]    s_size;
  logic [BW-1:0] s_beats;
  logic          s_fixed, s_write;
  logic [2:0]    s_burst;

  ahbm_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst(rst), .req(ch_req), .idle(!busy),
    .take(take), .grant_idx(grant_idx), .owner_idx(owner_idx)
  );

  ahbm_req_sel #(.NCH(NCH), .AW(AW), .BW(BW)) u_sel (
    .ch_addr(ch_addr), .ch_size(ch_size), .ch_beats(ch_beats),
    .ch_fixed(ch_fixed), .ch_write(ch_write), .sel(grant_idx),
    .s_addr(s_addr), .s_size(s_size), .s_beats(s_beats),
    .s_fixed(s_fixed), .s_write(s_write), .s_burst(s_burst)
  );

  ahbm_xfer_eng #(.AW(AW), .DW(DW), .BW(BW)) u_eng (
    .clk(clk), .rst(rst), .start(take),
    .st_addr(s_addr), .st_size(s_size), .st_beats(s_beats),
    .st_fixed(s_fixed), .st_write(s_write), .st_burst(s_burst),
    .busy(busy), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hready(hready), .hresp(hresp),
    .hrdata(hrdata), .dp_write(dp_write), .beat_ok(e_ok),
    .done(e_done), .err(e_err), .rdata(ch_rdata)
  );

  assign hwdata = dp_write ? ch_wdata[owner_idx] : '0;

  // The owner only changes on a grant, which comes after its done pulse.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) ch_start[g] <= 1'b0;
      else ch_start[g] <= take && (grant_idx == IW'(g));
    end
    assign ch_beat_ok[g] = e_ok   && (owner_idx == IW'(g));
    assign ch_done[g]    = e_done && (owner_idx == IW'(g));
    assign ch_err[g]     = e_err  && (owner_idx == IW'(g));
  end
endmodule

// File: rtl/ahbm_dual_master_chk.sv
module ahbm_dual_master_chk #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  haddr,
  input logic [1:0]     htrans,
  input logic [2:0]     hsize,
  input logic [2:0]     hburst,
  input logic           hready,
  input logic [1:0]     hresp,
  input logic [NCH-1:0] ch_start,
  input logic [NCH-1:0] ch_done,
  input logic [NCH-1:0] ch_err
);
  assert_seq_word_incr_R5: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'd3) |-> (hsize == 3'd2 && hburst == 3'd1));

  assert_seq_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (hready && htrans != 2'd0 && hburst == 3'd1) |=>
      (htrans != 2'd3 || haddr == $past(haddr) + AW'(4)));

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (htrans != 2'd0 && !hready && hresp == 2'd0) |=>
      ($stable(haddr) && $stable(htrans)));

  assert_resp_idle_R8_R9: assert property (@(posedge clk) disable iff (rst)
    (!hready && hresp != 2'd0) |=> (htrans == 2'd0));

  assert_no_busy_R12: assert property (@(posedge clk) disable iff (rst)
    htrans != 2'd1);

  assert_one_start_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_start));

  assert_err_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (|ch_err) |-> ((ch_err & ~ch_done) == '0));
endmodule

bind ahbm_dual_master ahbm_dual_master_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .haddr(haddr), .htrans(htrans), .hsize(hsize),
  .hburst(hburst), .hready(hready), .hresp(hresp),
  .ch_start(ch_start), .ch_done(ch_done), .ch_err(ch_err)
);

// File: tb/ahbm_dual_master_bench.sv
module ahbm_dual_master_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]       ch_req = '0;
  logic [1:0][31:0] ch_addr = '0;
  logic [1:0][1:0]  ch_size = '0;
  logic [1:0][4:0]  ch_beats = '0;
  logic [1:0]       ch_fixed = '0, ch_write = '0;
  logic [1:0][31:0] ch_wdata = '0;
  logic [1:0] ch_start, ch_beat_ok, ch_done, ch_err;
  logic [31:0] ch_rdata, haddr, hwdata;
  logic [31:0] hrdata = '0;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic        hready = 1'b1;
  logic [1:0]  hresp = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahbm_dual_master u_ahbm_dual_master (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_addr(ch_addr), .ch_size(ch_size),
    .ch_beats(ch_beats), .ch_fixed(ch_fixed), .ch_write(ch_write), .ch_wdata(ch_wdata),
    .ch_start(ch_start), .ch_beat_ok(ch_beat_ok), .ch_done(ch_done), .ch_err(ch_err),
    .ch_rdata(ch_rdata), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  int n_checks = 0, n_fail = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural model state
  bit m_busy = 0;
  int m_last = 0, m_own = 0, m_trans = 0, m_size = 0, m_burst = 0;
  bit m_fixed = 0, m_write = 0, m_dp = 0;
  logic [31:0] m_haddr = '0, m_dpaddr = '0, m_rdata = '0;
  logic [31:0] q[$];
  bit [1:0] m_start, m_ok, m_done, m_err;
  int okcnt[2] = '{0, 0};
  int acc_total = 0;

  // Slave script
  int fault_at = -1, fault_kind = 0, fault_stage = 0;
  bit wait_en = 0;
  int waited_idx = -1;
  bit rereq1 = 0;

  task automatic model_step();
    bit acc, fin, kill;
    int oldq, sel;
    logic [31:0] old_dp, popped;
    m_start = '0; m_ok = '0; m_done = '0; m_err = '0;
    if (rst) begin
      m_busy = 0; m_last = 0; m_trans = 0; m_dp = 0; q.delete();
      return;
    end
    if (!m_busy) begin
      if (ch_req != 0) begin
        sel = ch_req[m_last] ? m_last : 1 - m_last;
        m_last = sel; m_own = sel; m_busy = 1;
        m_size = int'(ch_size[sel]); m_fixed = ch_fixed[sel]; m_write = ch_write[sel];
        q.delete();
        for (int k = 0; k < int'(ch_beats[sel]); k++)
          q.push_back(ch_addr[sel] + (m_fixed ? 32'd0 : (32'(k) << m_size)));
        m_burst = (!m_fixed && m_size == 2 && ch_beats[sel] > 1) ? 1 : 0;
        m_trans = 2; m_haddr = q[0]; m_dp = 0;
        m_start[sel] = 1'b1;
      end
    end else begin
      acc = hready && m_trans != 0;
      fin = m_dp && hready;
      kill = m_dp && !hready && hresp != 2'd0;
      oldq = q.size();
      old_dp = m_dpaddr;
      if (fin) m_dp = 0;
      if (acc) begin
        popped = q.pop_front();
        m_dp = 1; m_dpaddr = popped; acc_total++;
        if (q.size() > 0) begin
          m_trans = (!m_fixed && m_size == 2) ? 3 : 2;
          m_haddr = q[0];
        end else m_trans = 0;
      end
      if (kill) m_trans = 0;
      if (fin) begin
        if (hresp == 2'd0) begin
          m_ok[m_own] = 1'b1; m_rdata = hrdata; okcnt[m_own]++;
          if (oldq == 0) begin m_done[m_own] = 1'b1; m_busy = 0; end
        end else if (hresp == 2'd1) begin
          m_err[m_own] = 1'b1; m_done[m_own] = 1'b1; m_busy = 0;
          q.delete(); m_trans = 0;
        end else begin
          q.push_front(old_dp); m_trans = 2; m_haddr = old_dp;
        end
      end
    end
  endtask

  task automatic compare();
    string tt;
    tt = (m_trans == 0) ? "R12" : m_fixed ? "R6" : (m_size == 2) ? "R5" : "R4";
    check(htrans == 2'(m_trans), {tag, "/", tt}, "htrans", htrans, m_trans);
    if (m_trans != 0) begin
      check(haddr == m_haddr, {tag, "/R3"}, "haddr", haddr, m_haddr);
      check(hsize == 3'(m_size), {tag, "/R3"}, "hsize", hsize, m_size);
      check(hwrite == m_write, {tag, "/R11"}, "hwrite", hwrite, m_write);
      check(hburst == 3'(m_burst), {tag, "/", tt}, "hburst", hburst, m_burst);
    end
    check(ch_start == m_start, {tag, "/R2"}, "ch_start", ch_start, m_start);
    check(ch_beat_ok == m_ok, {tag, "/R10"}, "ch_beat_ok", ch_beat_ok, m_ok);
    check(ch_done == m_done, {tag, "/R10"}, "ch_done", ch_done, m_done);
    check(ch_err == m_err, {tag, "/R9"}, "ch_err", ch_err, m_err);
    if (m_ok != 0 && !m_write)
      check(ch_rdata == m_rdata, {tag, "/R10"}, "ch_rdata", ch_rdata, m_rdata);
  endtask

  task automatic drive_slave();
    int idx;
    hready = 1'b1; hresp = 2'd0;
    if (m_dp) begin
      idx = acc_total - 1;
      hrdata = 32'hA500_0000 ^ m_dpaddr;
      if (idx == fault_at && fault_stage < 2) begin
        hready = (fault_stage == 1);
        hresp = 2'(fault_kind);
        fault_stage++;
      end else if (wait_en && idx != waited_idx && idx % 2 == 0) begin
        hready = 1'b0; waited_idx = idx;
      end
    end
  endtask

  // Main loop: model at the falling edge, then compare, then new inputs.
  always @(negedge clk) begin
    model_step();
    compare();
    for (int i = 0; i < 2; i++) if (m_start[i]) ch_req[i] = 1'b0;
    if (rereq1 && m_done[1]) begin ch_req[1] = 1'b1; rereq1 = 0; end
    drive_slave();
    for (int i = 0; i < 2; i++) ch_wdata[i] = {8'hC0 | 8'(i), 24'(okcnt[i])};
    #1;
    if (m_dp && m_write)
      check(hwdata == ch_wdata[m_own], {tag, "/R11"}, "hwdata", hwdata, ch_wdata[m_own]);
  end

  task automatic set_ch(input int c, input logic [31:0] a, input int sz, input int n,
                        input bit fx, input bit wr);
    ch_addr[c] = a; ch_size[c] = 2'(sz); ch_beats[c] = 5'(n);
    ch_fixed[c] = fx; ch_write[c] = wr;
  endtask

  task automatic issue(input int c);
    @(negedge clk); #2;
    ch_req[c] = 1'b1;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #3; end while (m_busy || ch_req != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #3;
    check(htrans == 2'd0 && ch_start == 0 && ch_done == 0 && ch_err == 0 && ch_beat_ok == 0,
          "R1", "reset state", {htrans, ch_start, ch_done}, 0);

    tag = "R5"; set_ch(0, 32'h100, 2, 4, 0, 0); issue(0); wait_idle();
    tag = "R4"; set_ch(1, 32'h201, 0, 3, 0, 1); issue(1); wait_idle();
    tag = "R3"; set_ch(0, 32'h302, 1, 3, 0, 0); issue(0); wait_idle();
    tag = "R6"; set_ch(0, 32'h402, 1, 3, 1, 0); issue(0); wait_idle();
    tag = "R6"; set_ch(1, 32'h500, 2, 4, 1, 1); issue(1); wait_idle();
    tag = "R7"; wait_en = 1; set_ch(0, 32'h600, 2, 5, 0, 1); issue(0); wait_idle();
    wait_en = 0;
    tag = "R8"; fault_at = acc_total + 2; fault_kind = 2; fault_stage = 0;
    set_ch(1, 32'h700, 2, 6, 0, 0); issue(1); wait_idle();
    tag = "R8"; fault_at = acc_total; fault_kind = 3; fault_stage = 0;
    set_ch(0, 32'h801, 0, 3, 0, 1); issue(0); wait_idle();
    tag = "R9"; fault_at = acc_total + 1; fault_kind = 1; fault_stage = 0;
    set_ch(1, 32'h900, 2, 4, 0, 0); issue(1); wait_idle();
    fault_at = -1;
    // Sticky grant: ch1 owns, ch0 waits, ch1 re-requests at once and wins.
    tag = "R2"; set_ch(1, 32'hA00, 2, 3, 0, 1); set_ch(0, 32'hB00, 2, 2, 0, 0);
    rereq1 = 1; issue(1); issue(0); wait_idle();
    // Simultaneous requests with ch0 as previous owner: ch0 first.
    tag = "R2"; @(negedge clk); #2 ch_req = 2'b11; wait_idle();
    tag = "R10"; set_ch(0, 32'hC00, 2, 1, 0, 0); issue(0); wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule